// File: doc/BRIEF.md
# Reset and Clock Startup Sequencer

This block decides when the rest of the chip gets a clock and when it leaves reset. It has three triggers: power-on, a qualified pulse on the external reset pin, and an interrupt that ends stop mode. The sequencer runs from an always-on reference (self) clock. Oscillator activity reaches it as single-cycle edge pulses that are already synchronous to that reference. A window monitor counts those pulses to judge whether the crystal oscillator is usable.

After power-on the sequencer checks the oscillator. If the check fails to pass within a timeout, the sequencer releases the system on the self clock. It moves back to the oscillator later, once the monitor reports good windows again. An external reset skips the check when the oscillator was already judged good at the moment the pin qualified. A stop-mode wake either repeats the check or, when both wake enables are set, resumes at once on the self clock. Internal reset asserts asynchronously and releases through a two-stage synchroniser. A power-on flag tells software whether RAM contents survived.

Top module: `clk_rst_seq`

## Requirements
- R1: While `por_n` is low: `int_rst_n` is 0, `cpu_run` is 0, `sys_clk_en` is 0, `clk_on_osc` is 0 and `por_flag` is 1.
- R2: The quality check splits time into windows of WIN_CYC reference cycles. A window passes when it holds at least MIN_EDGES `osc_edge` pulses. N_PASS consecutive passing windows make the oscillator good, and only then does `clk_on_osc` become 1 at release. An oscillator that delivers fewer edges per window is never selected.
- R3: If the oscillator is not good within TIMEOUT_CYC reference cycles of the check starting, the sequence continues with `clk_on_osc` = 0 (self clock).
- R4: While running on the self clock, `clk_on_osc` rises only after the monitor has reported the oscillator good. The switch back happens without any internal reset and without dropping `cpu_run`.
- R5: After the check, internal reset is held for HOLD_CYC further cycles. It then releases through two synchroniser stages. The time from power-on release to `cpu_run` = 1 lies between 96 and 4000 reference cycles.
- R6: `rst_pin_n` must stay low for at least PIN_MIN ticks before internal reset is asserted. A tick is one `osc_edge` pulse while running on a good oscillator, otherwise one reference cycle. Shorter pulses leave `int_rst_n` and `cpu_run` unchanged.
- R7: After a qualified pin reset, the check is skipped when the oscillator was good when the pin qualified. `cpu_run` then returns between HOLD_CYC and HOLD_CYC+10 cycles after the pin goes high. Otherwise the full check (with timeout) runs first.
- R8: A `stop_req` while running drops `cpu_run` and `sys_clk_en` on the next cycle. They stay 0 until a wake.
- R9: A `wake_irq` in stop mode with the fast path not enabled reruns the quality check. During the check `cpu_run` stays 0. `cpu_run` then returns on the oscillator, with no internal reset.
- R10: A `wake_irq` in stop mode with `fast_wake_en` and `self_clk_en` both 1 sets `cpu_run` = 1 and `clk_on_osc` = 0 on the next cycle.
- R11: `por_flag` is cleared by `por_flag_clr` and is set again only by power-on, not by a pin reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on self/reference clock |
| por_n | input | 1 | Power-on reset level, active low, asynchronous |
| rst_pin_n | input | 1 | External reset pin, active low, asynchronous |
| osc_edge | input | 1 | One-cycle pulse per oscillator edge, synchronous to clk |
| stop_req | input | 1 | Request to enter stop mode |
| wake_irq | input | 1 | Interrupt that ends stop mode |
| fast_wake_en | input | 1 | Enables the fast wake path |
| self_clk_en | input | 1 | Permits running on the self clock after wake |
| por_flag_clr | input | 1 | Software clear of the power-on flag |
| clk_on_osc | output | 1 | 1 = system clock is the oscillator, 0 = self clock |
| sys_clk_en | output | 1 | Clocks released to the system |
| int_rst_n | output | 1 | Internal reset, active low |
| cpu_run | output | 1 | CPU may execute |
| por_flag | output | 1 | Power-on occurred since the last clear |

## Verification
A pin pulse one tick short of the minimum must leave the system running; a filter with an off-by-one would reset on it, or would ignore a pulse of exactly the minimum. An oscillator with edges every eight cycles must lose to the timeout; a monitor comparing against the wrong threshold would select a weak clock. A pin reset with a good oscillator must recover in little more than the hold time, and one with a dead oscillator must take the full timeout; swapping these shows as a recovery time on the wrong side of the bound. The bench also checks that a normal wake keeps `cpu_run` low through the check, that a fast wake runs on the next cycle on the self clock, and that `por_flag` survives pin resets once cleared.

// File: rtl/crs_pkg.sv
package crs_pkg;

    typedef enum logic [2:0] {
        S_CHECK = 3'd0,
        S_HOLD  = 3'd1,
        S_RUN   = 3'd2,
        S_STOP  = 3'd3,
        S_PIN   = 3'd4
    } seq_state_e;

endpackage

// File: rtl/osc_qual_mon.sv
module osc_qual_mon #(
    parameter int WIN_CYC   = 16,
    parameter int MIN_EDGES = 4,
    parameter int N_PASS    = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic restart,
    input  logic osc_edge,
    output logic good,
    output logic win_end
);
    localparam int WW = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
    localparam int EW = $clog2(WIN_CYC + 2);
    localparam int PW = $clog2(N_PASS + 1);

    typedef struct packed {
        logic [WW-1:0] win_cnt;
        logic [EW-1:0] edge_cnt;
        logic [PW-1:0] streak;
        logic          good;
    } mon_t;

    mon_t q, d;
    logic [EW-1:0] edges_now;
    logic [PW-1:0] streak_nx;

    always_comb begin
        d         = q;
        win_end   = (q.win_cnt == WW'(WIN_CYC - 1));
        edges_now = q.edge_cnt + EW'(osc_edge);
        streak_nx = (q.streak == PW'(N_PASS)) ? q.streak : q.streak + PW'(1);
        if (win_end) begin
            d.win_cnt  = '0;
            d.edge_cnt = '0;
            if (edges_now >= EW'(MIN_EDGES)) begin
                d.streak = streak_nx;
                d.good   = (streak_nx == PW'(N_PASS));
            end else begin
                d.streak = '0;
                d.good   = 1'b0;
            end
        end else begin
            d.win_cnt  = q.win_cnt + WW'(1);
            d.edge_cnt = edges_now;
        end
        if (restart) begin
            d = '0;
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) q <= '0;
        else         q <= d;
    end

    assign good = q.good;

    // R2: the good flag only rises as a window closes
    a_r2_good_at_boundary: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(q.good) |-> $past(win_end));

    // R2: a window can never hold more edges than cycles
    a_r2_edge_bound: assert property (@(posedge clk) disable iff (!arst_n)
        q.edge_cnt <= EW'(WIN_CYC));

endmodule

// File: rtl/pin_filter.sv
module pin_filter #(
    parameter int PIN_MIN = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic rst_pin_n,
    input  logic tick,
    output logic pin_rst
);
    localparam int CW = $clog2(PIN_MIN + 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic [CW-1:0] cnt;
    } pf_t;

    pf_t q, d;

    always_comb begin
        d    = q;
        d.s1 = ~rst_pin_n;
        d.s2 = q.s1;
        if (!q.s2)                        d.cnt = '0;
        else if (q.cnt != CW'(PIN_MIN))   d.cnt = q.cnt + CW'(tick);
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) q <= '0;
        else         q <= d;
    end

    assign pin_rst = (q.cnt == CW'(PIN_MIN));

    // R6: a qualified pin reset needs the synchronised pin to have been low
    a_r6_needs_low: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(pin_rst) |-> $past(q.s2));

endmodule

// File: rtl/rst_sync.sv
module rst_sync (
    input  logic clk,
    input  logic arst_n,
    output logic rst_n_o
);
    typedef struct packed {
        logic s1;
        logic s2;
    } rs_t;

    rs_t q, d;

    always_comb begin
        d.s1 = 1'b1;
        d.s2 = q.s1;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) q <= '0;
        else         q <= d;
    end

    assign rst_n_o = q.s2;

endmodule

// File: rtl/clk_rst_seq.sv
module clk_rst_seq #(
    parameter int WIN_CYC     = 16,
    parameter int MIN_EDGES   = 4,
    parameter int N_PASS      = 2,
    parameter int TIMEOUT_CYC = 200,
    parameter int HOLD_CYC    = 96,
    parameter int PIN_MIN     = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic rst_pin_n,
    input  logic osc_edge,
    input  logic stop_req,
    input  logic wake_irq,
    input  logic fast_wake_en,
    input  logic self_clk_en,
    input  logic por_flag_clr,
    output logic clk_on_osc,
    output logic sys_clk_en,
    output logic int_rst_n,
    output logic cpu_run,
    output logic por_flag
);
    import crs_pkg::*;

    localparam int TW = $clog2(TIMEOUT_CYC);
    localparam int HW = $clog2(HOLD_CYC);

    typedef struct packed {
        seq_state_e    st;
        logic [TW-1:0] tmo;
        logic [HW-1:0] hold;
        logic          osc_sel;
        logic          rst_req;
        logic          por_flag;
        logic          resume;
        logic          skip;
    } seq_t;

    seq_t q, d;
    logic mon_restart;
    logic mon_good;
    logic mon_win_end;
    logic pin_rst;
    logic pin_tick;
    logic sync_arst_n;

    assign pin_tick = (q.osc_sel && mon_good) ? osc_edge : 1'b1;

    osc_qual_mon #(
        .WIN_CYC  (WIN_CYC),
        .MIN_EDGES(MIN_EDGES),
        .N_PASS   (N_PASS)
    ) u_mon (
        .clk     (clk),
        .arst_n  (por_n),
        .restart (mon_restart),
        .osc_edge(osc_edge),
        .good    (mon_good),
        .win_end (mon_win_end)
    );

    pin_filter #(
        .PIN_MIN(PIN_MIN)
    ) u_pin (
        .clk      (clk),
        .arst_n   (por_n),
        .rst_pin_n(rst_pin_n),
        .tick     (pin_tick),
        .pin_rst  (pin_rst)
    );

    assign sync_arst_n = por_n & ~q.rst_req;

    rst_sync u_rsync (
        .clk    (clk),
        .arst_n (sync_arst_n),
        .rst_n_o(int_rst_n)
    );

    always_comb begin
        d           = q;
        mon_restart = 1'b0;
        d.por_flag  = q.por_flag & ~por_flag_clr;
        unique case (q.st)
            S_CHECK: begin
                d.tmo = q.tmo + TW'(1);
                if (mon_good || (q.tmo == TW'(TIMEOUT_CYC - 1))) begin
                    d.osc_sel = mon_good;
                    if (q.resume) begin
                        d.st     = S_RUN;
                        d.resume = 1'b0;
                    end else begin
                        d.st   = S_HOLD;
                        d.hold = '0;
                    end
                end
            end
            S_HOLD: begin
                d.rst_req = 1'b1;
                if (q.hold == HW'(HOLD_CYC - 1)) begin
                    d.rst_req = 1'b0;
                    d.st      = S_RUN;
                end else begin
                    d.hold = q.hold + HW'(1);
                end
            end
            S_RUN: begin
                if (!q.osc_sel && mon_good) d.osc_sel = 1'b1;
                if (stop_req)               d.st      = S_STOP;
            end
            S_STOP: begin
                if (wake_irq) begin
                    mon_restart = 1'b1;
                    d.osc_sel   = 1'b0;
                    if (fast_wake_en && self_clk_en) begin
                        d.st = S_RUN;
                    end else begin
                        d.st     = S_CHECK;
                        d.tmo    = '0;
                        d.resume = 1'b1;
                    end
                end
            end
            S_PIN: begin
                d.rst_req = 1'b1;
                if (!pin_rst) begin
                    if (q.skip && mon_good) begin
                        d.st      = S_HOLD;
                        d.hold    = '0;
                        d.osc_sel = 1'b1;
                    end else begin
                        d.st        = S_CHECK;
                        d.tmo       = '0;
                        d.resume    = 1'b0;
                        d.osc_sel   = 1'b0;
                        mon_restart = 1'b1;
                    end
                end
            end
            default: d.st = S_CHECK;
        endcase
        if (pin_rst) begin
            if (q.st != S_PIN) d.skip = mon_good;
            d.st      = S_PIN;
            d.rst_req = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            q.st       <= S_CHECK;
            q.tmo      <= '0;
            q.hold     <= '0;
            q.osc_sel  <= 1'b0;
            q.rst_req  <= 1'b1;
            q.por_flag <= 1'b1;
            q.resume   <= 1'b0;
            q.skip     <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign clk_on_osc = q.osc_sel;
    assign sys_clk_en = (q.st == S_HOLD) || (q.st == S_RUN);
    assign cpu_run    = (q.st == S_RUN) && int_rst_n;
    assign por_flag   = q.por_flag;

    // R3: the check never outlives its timeout
    a_r3_timeout_bound: assert property (@(posedge clk) disable iff (!por_n)
        (q.st == S_CHECK) |-> (q.tmo < TW'(TIMEOUT_CYC)));

    // R4: the oscillator is selected only after the monitor reported it good
    a_r4_switch_on_good: assert property (@(posedge clk) disable iff (!por_n)
        $rose(q.osc_sel) |-> $past(mon_good));

    // R5: internal reset stays asserted through the hold phase
    a_r5_reset_in_hold: assert property (@(posedge clk) disable iff (!por_n)
        (q.st == S_HOLD) |-> !int_rst_n);

    // R8: a stop request halts the CPU on the next cycle
    a_r8_stop_halts: assert property (@(posedge clk) disable iff (!por_n)
        (q.st == S_RUN && stop_req && !pin_rst) |=> !cpu_run);

    // R10: fast wake runs at once on the self clock
    a_r10_fast_wake: assert property (@(posedge clk) disable iff (!por_n)
        (q.st == S_STOP && wake_irq && fast_wake_en && self_clk_en && !pin_rst)
        |=> (cpu_run && !clk_on_osc));

    // R11: once cleared, only power-on sets the flag again
    a_r11_flag_sticky: assert property (@(posedge clk) disable iff (!por_n)
        !q.por_flag |=> !q.por_flag);

endmodule

// File: tb/tb_clk_rst_seq.sv
module tb_clk_rst_seq;

    localparam int CLK_PERIOD = 10;
    localparam int WIN        = 16;
    localparam int MINE       = 4;
    localparam int NP         = 2;
    localparam int TMO        = 200;
    localparam int HOLD       = 96;
    localparam int PMIN       = 2;
    localparam int WD_CYCLES  = 150000;

    typedef struct packed {
        logic [7:0] width;
        logic       exp_rst;
    } pin_vec_t;

    localparam int NV = 5;
    localparam pin_vec_t VEC [NV] = '{
        '{width: 8'd1, exp_rst: 1'b0},
        '{width: 8'd2, exp_rst: 1'b1},
        '{width: 8'd3, exp_rst: 1'b1},
        '{width: 8'd1, exp_rst: 1'b0},
        '{width: 8'd5, exp_rst: 1'b1}
    };

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic rst_pin_n = 1'b1;
    logic osc_edge = 1'b0;
    logic stop_req = 1'b0;
    logic wake_irq = 1'b0;
    logic fast_wake_en = 1'b0;
    logic self_clk_en = 1'b0;
    logic por_flag_clr = 1'b0;
    logic clk_on_osc, sys_clk_en, int_rst_n, cpu_run, por_flag;

    int n_vec = 0;
    int n_bad = 0;
    int osc_per = 1;
    int ph = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (osc_per == 0) begin
            osc_edge <= 1'b0;
            ph       <= 0;
        end else begin
            osc_edge <= (ph == 0);
            ph       <= (ph + 1 >= osc_per) ? 0 : ph + 1;
        end
    end

    clk_rst_seq #(
        .WIN_CYC(WIN), .MIN_EDGES(MINE), .N_PASS(NP),
        .TIMEOUT_CYC(TMO), .HOLD_CYC(HOLD), .PIN_MIN(PMIN)
    ) dut (
        .clk(clk), .por_n(por_n), .rst_pin_n(rst_pin_n), .osc_edge(osc_edge),
        .stop_req(stop_req), .wake_irq(wake_irq), .fast_wake_en(fast_wake_en),
        .self_clk_en(self_clk_en), .por_flag_clr(por_flag_clr),
        .clk_on_osc(clk_on_osc), .sys_clk_en(sys_clk_en), .int_rst_n(int_rst_n),
        .cpu_run(cpu_run), .por_flag(por_flag)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_por();
        @(negedge clk) por_n = 1'b0;
        repeat (4) @(negedge clk);
        por_n = 1'b1;
    endtask

    task automatic wait_run(input int maxc, output int n, output bit saw_rst);
        n = 0;
        saw_rst = 1'b0;
        while (!cpu_run && n < maxc) begin
            @(negedge clk);
            n++;
            if (!int_rst_n) saw_rst = 1'b1;
        end
    endtask

    // drive a pin pulse, then measure whether reset fired and how long recovery took
    task automatic pin_pulse(input int w, output bit saw, output int rec);
        @(negedge clk) rst_pin_n = 1'b0;
        repeat (w - 1) @(negedge clk);
        @(negedge clk) rst_pin_n = 1'b1;
        saw = 1'b0;
        rec = 0;
        for (int c = 1; c <= 1000; c++) begin
            @(negedge clk);
            if (!int_rst_n) saw = 1'b1;
            rec = c;
            if (saw && cpu_run) break;
            if (!saw && c >= 12) break;
        end
    endtask

    initial begin
        int  lat;
        bit  sr;
        bit  saw;
        int  rec;
        bit  run_drop;

        // R1: state while power-on reset is held
        repeat (3) @(negedge clk);
        check("R1 int_rst_n", int_rst_n, 0);
        check("R1 cpu_run", cpu_run, 0);
        check("R1 sys_clk_en", sys_clk_en, 0);
        check("R1 clk_on_osc", clk_on_osc, 0);
        check("R1 por_flag", por_flag, 1);
        por_n = 1'b1;

        // R5, R2: startup with a healthy oscillator
        wait_run(5000, lat, sr);
        check("R5 run latency in range", int'(lat >= 96 && lat <= 4000), 1);
        check("R2 oscillator selected", clk_on_osc, 1);

        // R11: software clear
        check("R11 flag after power-on", por_flag, 1);
        @(negedge clk) por_flag_clr = 1'b1;
        @(negedge clk) por_flag_clr = 1'b0;
        check("R11 flag cleared", por_flag, 0);

        // R6, R7: pin pulse width table
        for (int i = 0; i < NV; i++) begin
            pin_pulse(int'(VEC[i].width), saw, rec);
            check($sformatf("R6 width %0d reset", VEC[i].width), saw, VEC[i].exp_rst);
            if (VEC[i].exp_rst)
                check("R7 skip check recovery", int'(rec >= HOLD && rec <= HOLD + 10), 1);
            else
                check("R6 short pulse keeps run", cpu_run, 1);
        end
        check("R11 flag not set by pin", por_flag, 0);

        // R8: stop
        @(negedge clk) stop_req = 1'b1;
        @(negedge clk) stop_req = 1'b0;
        check("R8 cpu halted", cpu_run, 0);
        check("R8 clocks gated", sys_clk_en, 0);
        repeat (20) @(negedge clk);
        check("R8 still halted", cpu_run, 0);

        // R10: fast wake
        fast_wake_en = 1'b1;
        self_clk_en  = 1'b1;
        @(negedge clk) wake_irq = 1'b1;
        @(negedge clk) wake_irq = 1'b0;
        check("R10 runs next cycle", cpu_run, 1);
        check("R10 on self clock", clk_on_osc, 0);

        // R4: back to the oscillator without reset or halt
        run_drop = 1'b0;
        for (int c = 0; c < 100 && !clk_on_osc; c++) begin
            @(negedge clk);
            if (!cpu_run || !int_rst_n) run_drop = 1'b1;
        end
        check("R4 switched back", clk_on_osc, 1);
        check("R4 no disturbance", run_drop, 0);

        // R9: normal wake reruns the check
        @(negedge clk) stop_req = 1'b1;
        @(negedge clk) stop_req = 1'b0;
        self_clk_en = 1'b0;
        @(negedge clk) wake_irq = 1'b1;
        @(negedge clk) wake_irq = 1'b0;
        check("R9 held during check", cpu_run, 0);
        wait_run(300, lat, sr);
        check("R9 resumed", cpu_run, 1);
        check("R9 check duration", int'(lat + 1 >= WIN * NP), 1);
        check("R9 on oscillator", clk_on_osc, 1);
        check("R9 no internal reset", sr, 0);
        fast_wake_en = 1'b0;

        // R3: dead oscillator times out to the self clock
        osc_per = 0;
        do_por();
        check("R1 flag set by power-on", por_flag, 1);
        wait_run(5000, lat, sr);
        check("R3 released", cpu_run, 1);
        check("R3 on self clock", clk_on_osc, 0);
        check("R3 waited timeout", int'(lat >= TMO + HOLD && lat <= 4000), 1);

        // R4: oscillator appears later
        osc_per = 1;
        run_drop = 1'b0;
        for (int c = 0; c < 100 && !clk_on_osc; c++) begin
            @(negedge clk);
            if (!cpu_run) run_drop = 1'b1;
        end
        check("R4 late oscillator selected", clk_on_osc, 1);
        check("R4 run kept", run_drop, 0);

        // R2: too few edges per window never qualifies
        osc_per = 8;
        do_por();
        wait_run(5000, lat, sr);
        check("R2 weak oscillator rejected", clk_on_osc, 0);
        check("R2 still released", cpu_run, 1);

        // R7: pin reset with no good oscillator takes the full check
        osc_per = 0;
        pin_pulse(3, saw, rec);
        check("R7 reset taken", saw, 1);
        check("R7 full check recovery", int'(rec >= TMO + HOLD), 1);

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", WD_CYCLES, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule